// File: doc/BRIEF.md
# Indirect EEPROM and PHY word access sequencer

This block runs on the host side of an Ethernet controller that exposes its internal registers through one byte-wide indexed port. Each register access uses two bus cycles. In the first cycle an index strobe puts the register number on the bus. In the second cycle a data strobe writes or reads one byte. Through that port the sequencer reads and writes 16-bit words in the controller's serial configuration EEPROM or in its PHY management registers. It can also ask the controller to reload its settings from the EEPROM.

A client issues one command by pulsing `cmd_valid` while `ready` is high. The command carries a target, an operation, a word offset and, for writes, a data word. The sequencer then works through a fixed list of register accesses that depends on the target and the operation:

- it programs the offset;
- it writes the data bytes, for writes only;
- it sets the request bits in the control register;
- it polls the busy bit, for EEPROM operations only;
- it waits a settle time set by a parameter in clock cycles;
- it clears the control register;
- it reads back the data bytes, for reads only.

When the list is complete, `done` pulses for one cycle and `rdata` holds the word that was read.

Top module: `eep_phy_seq`

## Requirements
- R1: During and right after reset, `ready`=1, `done`=0, `bus_wr`=0, `bus_rd`=0 and `rdata`=0. A reset in the middle of a command abandons it and returns to this state.
- R2: Every register access is an index cycle followed directly by a data cycle. The index cycle has `bus_wr`=1, `bus_idx`=1 and `bus_wdata` equal to the register number. The data cycle has `bus_idx`=0 and either `bus_wr`=1 (write) or `bus_rd`=1 (read, with the byte sampled from `bus_rdata`).
- R3: EEPROM read (target 0, op 0) performs these accesses in order:
  - 0x0C is written with the offset;
  - 0x0B is written with 0x04;
  - 0x0B is polled;
  - the sequencer waits EEP_SETTLE cycles;
  - 0x0B is written with 0x00;
  - 0x0D is read, then 0x0E is read.
  
  `rdata` = {byte read from 0x0E, byte read from 0x0D}.
- R4: EEPROM write (target 0, op 1) performs these accesses in order:
  - 0x0C is written with the offset;
  - 0x0E is written with `wdata[15:8]`;
  - 0x0D is written with `wdata[7:0]`;
  - 0x0B is written with 0x12;
  - 0x0B is polled;
  - the sequencer waits EEP_SETTLE cycles;
  - 0x0B is written with 0x00.
- R5: Reload (op 2 or op 3, with either target) performs these accesses in order:
  - 0x0B is written with 0x20;
  - 0x0B is polled;
  - the sequencer waits EEP_SETTLE cycles;
  - 0x0B is written with 0x00.
- R6: PHY read (target 1, op 0) performs these accesses in order, with no poll:
  - 0x0C is written with 0x40 + offset;
  - 0x0B is written with 0x0C;
  - the sequencer waits PHY_RD_SETTLE cycles;
  - 0x0B is written with 0x00;
  - 0x0D is read, then 0x0E is read.
  
  `rdata` is assembled as in R3.
- R7: PHY write (target 1, op 1) performs these accesses in order, with no poll:
  - 0x0C is written with 0x40 + offset;
  - 0x0D is written with `wdata[7:0]`;
  - 0x0E is written with `wdata[15:8]`;
  - 0x0B is written with 0x0A;
  - the sequencer waits PHY_WR_SETTLE cycles;
  - 0x0B is written with 0x00.
- R8: A poll is an index write of 0x0B followed by a data read. While bit 0 of the byte read is 1, the whole poll access repeats. The first read with bit 0 = 0 ends the poll.
- R9: A wait of N cycles leaves exactly N+1 cycles with no strobe between the data cycle before it and the next index cycle. Counted from the clock edge that accepts a command, `done` is first high after (2 × accesses) + N + 2 edges.
- R10: `done` is high for exactly one cycle, in the cycle after the final data cycle, and `ready` is high in the cycle after that. `rdata` changes only during read commands.
- R11: A command is accepted only on an edge where `cmd_valid`=1 and `ready`=1. While a command runs, `ready`=0, and `cmd_valid` together with any command fields is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when `ready` is high |
| cmd_target | input | 1 | 0 = EEPROM, 1 = PHY |
| cmd_op | input | 2 | 0 = read, 1 = write, 2 or 3 = reload |
| cmd_offset | input | OFS_W | Word offset or PHY register number |
| cmd_wdata | input | 16 | Word to write |
| ready | output | 1 | Idle and able to take a command |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word from the last read command |
| bus_wr | output | 1 | Write strobe on the indexed port |
| bus_rd | output | 1 | Read strobe on the indexed port |
| bus_idx | output | 1 | 1 = index cycle, 0 = data cycle |
| bus_wdata | output | 8 | Index or data byte driven to the port |
| bus_rdata | input | 8 | Byte returned by the port during a read strobe |

## Verification
The bench's responder holds the busy bit high for a chosen number of polls. A design that skipped the poll, or stopped after one busy read, would show the wrong access trace and the wrong latency. PHY operations are checked to contain no poll at all. They are also checked to apply the 0x40 bias, which a design that shared the EEPROM path would drop. The opposite byte orders of the EEPROM and PHY data writes are checked by a write followed by a read-back. A wait that was off by one shows up as a latency mismatch. Competing commands are pushed while the sequencer is busy, and a reset is applied in the middle of a poll. A design that accepted the extra command would emit foreign accesses, and one that failed to recover would leave `ready` low.

// File: rtl/eps_pkg.sv
package eps_pkg;
  localparam int STEP_W = 4;

  // Register numbers on the indexed port
  localparam logic [7:0] IX_CTRL = 8'h0B;
  localparam logic [7:0] IX_ADDR = 8'h0C;
  localparam logic [7:0] IX_DLO  = 8'h0D;
  localparam logic [7:0] IX_DHI  = 8'h0E;
  localparam logic [7:0] PHY_BIAS = 8'h40;

  // Control register bit positions
  localparam int CB_BUSY   = 0;
  localparam int CB_WR     = 1;
  localparam int CB_RD     = 2;
  localparam int CB_PHY    = 3;
  localparam int CB_WEN    = 4;
  localparam int CB_RELOAD = 5;

  localparam logic [7:0] CTL_EEP_RD = 8'(1 << CB_RD);
  localparam logic [7:0] CTL_EEP_WR = 8'((1 << CB_WEN) | (1 << CB_WR));
  localparam logic [7:0] CTL_RELOAD = 8'(1 << CB_RELOAD);
  localparam logic [7:0] CTL_PHY_RD = 8'((1 << CB_PHY) | (1 << CB_RD));
  localparam logic [7:0] CTL_PHY_WR = 8'((1 << CB_PHY) | (1 << CB_WR));

  typedef enum logic [2:0] {U_WREG, U_RLO, U_RHI, U_POLL, U_WAIT} ukind_e;
  typedef enum logic [2:0] {V_CONST, V_OFS, V_PHYOFS, V_WLO, V_WHI} vsrc_e;
  typedef enum logic [1:0] {D_EEP, D_PHYRD, D_PHYWR} dsel_e;

  typedef struct packed {
    ukind_e     kind;
    logic [7:0] idx;
    vsrc_e      src;
    logic [7:0] cval;
    dsel_e      dsel;
    logic       last;
  } uop_t;
endpackage

// File: rtl/eps_step_rom.sv
module eps_step_rom
  import eps_pkg::*;
(
  input  logic              tgt_phy,
  input  logic [1:0]        op,
  input  logic [STEP_W-1:0] step,
  output uop_t              uop
);
  function automatic uop_t mk(ukind_e k, logic [7:0] ix, vsrc_e s,
                              logic [7:0] c, dsel_e d, logic l);
    uop_t u;
    u.kind = k; u.idx = ix; u.src = s; u.cval = c; u.dsel = d; u.last = l;
    return u;
  endfunction

  always_comb begin
    uop = mk(U_WREG, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b1);
    if (op[1]) begin
      case (step)
        4'd0: uop = mk(U_WREG, IX_CTRL, V_CONST, CTL_RELOAD, D_EEP, 1'b0);
        4'd1: uop = mk(U_POLL, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        4'd2: uop = mk(U_WAIT, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        default: ;
      endcase
    end else if (!tgt_phy && !op[0]) begin
      case (step)
        4'd0: uop = mk(U_WREG, IX_ADDR, V_OFS, 8'h00, D_EEP, 1'b0);
        4'd1: uop = mk(U_WREG, IX_CTRL, V_CONST, CTL_EEP_RD, D_EEP, 1'b0);
        4'd2: uop = mk(U_POLL, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        4'd3: uop = mk(U_WAIT, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        4'd4: uop = mk(U_WREG, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        4'd5: uop = mk(U_RLO, IX_DLO, V_CONST, 8'h00, D_EEP, 1'b0);
        4'd6: uop = mk(U_RHI, IX_DHI, V_CONST, 8'h00, D_EEP, 1'b1);
        default: ;
      endcase
    end else if (!tgt_phy) begin
      case (step)
        4'd0: uop = mk(U_WREG, IX_ADDR, V_OFS, 8'h00, D_EEP, 1'b0);
        4'd1: uop = mk(U_WREG, IX_DHI, V_WHI, 8'h00, D_EEP, 1'b0);
        4'd2: uop = mk(U_WREG, IX_DLO, V_WLO, 8'h00, D_EEP, 1'b0);
        4'd3: uop = mk(U_WREG, IX_CTRL, V_CONST, CTL_EEP_WR, D_EEP, 1'b0);
        4'd4: uop = mk(U_POLL, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        4'd5: uop = mk(U_WAIT, IX_CTRL, V_CONST, 8'h00, D_EEP, 1'b0);
        default: ;
      endcase
    end else if (!op[0]) begin
      case (step)
        4'd0: uop = mk(U_WREG, IX_ADDR, V_PHYOFS, 8'h00, D_PHYRD, 1'b0);
        4'd1: uop = mk(U_WREG, IX_CTRL, V_CONST, CTL_PHY_RD, D_PHYRD, 1'b0);
        4'd2: uop = mk(U_WAIT, IX_CTRL, V_CONST, 8'h00, D_PHYRD, 1'b0);
        4'd3: uop = mk(U_WREG, IX_CTRL, V_CONST, 8'h00, D_PHYRD, 1'b0);
        4'd4: uop = mk(U_RLO, IX_DLO, V_CONST, 8'h00, D_PHYRD, 1'b0);
        4'd5: uop = mk(U_RHI, IX_DHI, V_CONST, 8'h00, D_PHYRD, 1'b1);
        default: ;
      endcase
    end else begin
      case (step)
        4'd0: uop = mk(U_WREG, IX_ADDR, V_PHYOFS, 8'h00, D_PHYWR, 1'b0);
        4'd1: uop = mk(U_WREG, IX_DLO, V_WLO, 8'h00, D_PHYWR, 1'b0);
        4'd2: uop = mk(U_WREG, IX_DHI, V_WHI, 8'h00, D_PHYWR, 1'b0);
        4'd3: uop = mk(U_WREG, IX_CTRL, V_CONST, CTL_PHY_WR, D_PHYWR, 1'b0);
        4'd4: uop = mk(U_WAIT, IX_CTRL, V_CONST, 8'h00, D_PHYWR, 1'b0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eps_settle_timer.sv
module eps_settle_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = (cnt_q <= CNT_W'(1));

  // R9
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > CNT_W'(1)) |=> !fire);
endmodule

// File: rtl/eep_phy_seq.sv
module eep_phy_seq
  import eps_pkg::*;
#(
  parameter int OFS_W         = 6,
  parameter int EEP_SETTLE    = 800000,
  parameter int PHY_RD_SETTLE = 20000,
  parameter int PHY_WR_SETTLE = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_target,
  input  logic [1:0]       cmd_op,
  input  logic [OFS_W-1:0] cmd_offset,
  input  logic [15:0]      cmd_wdata,
  output logic             ready,
  output logic             done,
  output logic [15:0]      rdata,
  output logic             bus_wr,
  output logic             bus_rd,
  output logic             bus_idx,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata
);
  localparam int MAX_A = (EEP_SETTLE > PHY_RD_SETTLE) ? EEP_SETTLE : PHY_RD_SETTLE;
  localparam int MAX_W = (MAX_A > PHY_WR_SETTLE) ? MAX_A : PHY_WR_SETTLE;
  localparam int CNT_W = $clog2(MAX_W + 1) < 1 ? 1 : $clog2(MAX_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_IDX, S_DATA, S_WAIT, S_FIN} st_e;

  st_e               state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              tgt_q;
  logic [1:0]        op_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [15:0]       wdata_q;
  logic [15:0]       rdata_q;
  logic              cmd_en, lo_en, hi_en;
  logic              tmr_load, tmr_fire;
  logic [CNT_W-1:0]  tmr_val;
  logic [7:0]        val;
  uop_t              uop;

  eps_step_rom u_rom (
    .tgt_phy (tgt_q),
    .op      (op_q),
    .step    (step_q),
    .uop     (uop)
  );

  eps_settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .run      (state_q == S_WAIT),
    .load_val (tmr_val),
    .fire     (tmr_fire)
  );

  always_comb begin
    case (uop.dsel)
      D_PHYRD: tmr_val = CNT_W'(PHY_RD_SETTLE);
      D_PHYWR: tmr_val = CNT_W'(PHY_WR_SETTLE);
      default: tmr_val = CNT_W'(EEP_SETTLE);
    endcase
    case (uop.src)
      V_OFS:    val = 8'(ofs_q);
      V_PHYOFS: val = PHY_BIAS + 8'(ofs_q);
      V_WLO:    val = wdata_q[7:0];
      V_WHI:    val = wdata_q[15:8];
      default:  val = uop.cval;
    endcase
  end

  // Next-state and bus drive
  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    cmd_en    = 1'b0;
    lo_en     = 1'b0;
    hi_en     = 1'b0;
    tmr_load  = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_idx   = 1'b0;
    bus_wdata = 8'h00;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          cmd_en  = 1'b1;
          step_d  = '0;
          state_d = S_IDX;
        end
      end
      S_IDX: begin
        if (uop.kind == U_WAIT) begin
          tmr_load = 1'b1;
          state_d  = S_WAIT;
        end else begin
          bus_wr    = 1'b1;
          bus_idx   = 1'b1;
          bus_wdata = uop.idx;
          state_d   = S_DATA;
        end
      end
      S_DATA: begin
        if (uop.kind == U_WREG) begin
          bus_wr    = 1'b1;
          bus_wdata = val;
        end else begin
          bus_rd = 1'b1;
        end
        lo_en = (uop.kind == U_RLO);
        hi_en = (uop.kind == U_RHI);
        if (uop.kind == U_POLL && bus_rdata[CB_BUSY]) begin
          state_d = S_IDX;
        end else if (uop.last) begin
          state_d = S_FIN;
        end else begin
          step_d  = step_q + STEP_W'(1);
          state_d = S_IDX;
        end
      end
      S_WAIT: begin
        if (tmr_fire) begin
          step_d  = step_q + STEP_W'(1);
          state_d = S_IDX;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= 1'b0;
      op_q    <= 2'b00;
      ofs_q   <= '0;
      wdata_q <= 16'h0000;
    end else if (cmd_en) begin
      tgt_q   <= cmd_target;
      op_q    <= cmd_op;
      ofs_q   <= cmd_offset;
      wdata_q <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 16'h0000;
    end else begin
      if (lo_en) rdata_q[7:0]  <= bus_rdata;
      if (hi_en) rdata_q[15:8] <= bus_rdata;
    end
  end

  assign ready = (state_q == S_IDLE);
  assign done  = (state_q == S_FIN);
  assign rdata = rdata_q;

  // R2
  idx_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_idx) |-> $past(bus_wr && bus_idx));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> ($stable(tgt_q) && $stable(op_q) &&
                                   $stable(ofs_q) && $stable(wdata_q)));

  // R8
  poll_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA && uop.kind == U_POLL && bus_rdata[CB_BUSY])
      |=> (bus_wr && bus_idx && bus_wdata == IX_CTRL));
endmodule

// File: tb/sim_eep_phy_seq.sv
module sim_eep_phy_seq;
  localparam int EW = 5;
  localparam int PRW = 3;
  localparam int PWW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_target = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [5:0]  cmd_offset = '0;
  logic [15:0] cmd_wdata = '0;
  logic        ready, done, bus_wr, bus_rd, bus_idx;
  logic [15:0] rdata;
  logic [7:0]  bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  eep_phy_seq #(.OFS_W(6), .EEP_SETTLE(EW), .PHY_RD_SETTLE(PRW),
                .PHY_WR_SETTLE(PWW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_target(cmd_target),
    .cmd_op(cmd_op), .cmd_offset(cmd_offset), .cmd_wdata(cmd_wdata),
    .ready(ready), .done(done), .rdata(rdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Responder model of the controller's indexed port
  logic [7:0]  regs [0:255];
  logic [15:0] eep_mem [0:63];
  logic [15:0] phy_mem [0:63];
  logic [7:0]  cur_idx = 8'h00;
  int          busy_cnt = 0;
  int          busy_n = 0;
  bit          pend_dec = 0;

  assign bus_rdata = (cur_idx == 8'h0B) ? {7'b0, busy_cnt != 0} : regs[cur_idx];

  // Trace log
  int        log_n = 0;
  int        log_ty [0:63];
  logic [7:0] log_v [0:63];
  int        exp_n = 0;
  int        exp_ty [0:63];
  logic [7:0] exp_v [0:63];

  always @(negedge clk) begin
    if (pend_dec) begin
      if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
      pend_dec = 0;
    end
    if (rst_n && (bus_wr || bus_rd)) begin
      if (log_n < 64) begin
        log_ty[log_n] = bus_rd ? 2 : (bus_idx ? 0 : 1);
        log_v[log_n]  = bus_rd ? bus_rdata : bus_wdata;
      end
      log_n = log_n + 1;
    end
    if (rst_n && bus_wr && bus_idx) cur_idx = bus_wdata;
    if (rst_n && bus_rd && cur_idx == 8'h0B) pend_dec = 1;
    if (rst_n && bus_wr && !bus_idx) begin
      regs[cur_idx] = bus_wdata;
      if (cur_idx == 8'h0B) begin
        if (bus_wdata[2]) begin
          if (bus_wdata[3]) begin
            regs[8'h0D] = phy_mem[6'(regs[8'h0C] - 8'h40)][7:0];
            regs[8'h0E] = phy_mem[6'(regs[8'h0C] - 8'h40)][15:8];
          end else begin
            regs[8'h0D] = eep_mem[regs[8'h0C][5:0]][7:0];
            regs[8'h0E] = eep_mem[regs[8'h0C][5:0]][15:8];
          end
        end
        if (bus_wdata[1]) begin
          if (bus_wdata[3]) phy_mem[6'(regs[8'h0C] - 8'h40)] = {regs[8'h0E], regs[8'h0D]};
          else              eep_mem[regs[8'h0C][5:0]] = {regs[8'h0E], regs[8'h0D]};
        end
        if (!bus_wdata[3] && (bus_wdata[1] || bus_wdata[2] || bus_wdata[5]))
          busy_cnt = busy_n;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic ex_w(input logic [7:0] ix, input logic [7:0] v);
    exp_ty[exp_n] = 0; exp_v[exp_n] = ix; exp_n = exp_n + 1;
    exp_ty[exp_n] = 1; exp_v[exp_n] = v;  exp_n = exp_n + 1;
  endtask

  task automatic ex_r(input logic [7:0] ix, input logic [7:0] v);
    exp_ty[exp_n] = 0; exp_v[exp_n] = ix; exp_n = exp_n + 1;
    exp_ty[exp_n] = 2; exp_v[exp_n] = v;  exp_n = exp_n + 1;
  endtask

  task automatic ex_poll(input int b);
    for (int i = 0; i < b; i++) ex_r(8'h0B, 8'h01);
    ex_r(8'h0B, 8'h00);
  endtask

  // Builds the expected access list from the requirements; returns wait length and tag
  task automatic build_exp(input logic t, input logic [1:0] op, input logic [5:0] ofs,
                           input logic [15:0] wd, input int b, input logic [15:0] word,
                           output int nwait, output string tag);
    exp_n = 0;
    if (op[1]) begin
      tag = "R5"; nwait = EW;
      ex_w(8'h0B, 8'h20); ex_poll(b); ex_w(8'h0B, 8'h00);
    end else if (!t && op == 2'd0) begin
      tag = "R3"; nwait = EW;
      ex_w(8'h0C, {2'b0, ofs}); ex_w(8'h0B, 8'h04); ex_poll(b); ex_w(8'h0B, 8'h00);
      ex_r(8'h0D, word[7:0]); ex_r(8'h0E, word[15:8]);
    end else if (!t) begin
      tag = "R4"; nwait = EW;
      ex_w(8'h0C, {2'b0, ofs}); ex_w(8'h0E, wd[15:8]); ex_w(8'h0D, wd[7:0]);
      ex_w(8'h0B, 8'h12); ex_poll(b); ex_w(8'h0B, 8'h00);
    end else if (op == 2'd0) begin
      tag = "R6"; nwait = PRW;
      ex_w(8'h0C, 8'h40 + {2'b0, ofs}); ex_w(8'h0B, 8'h0C); ex_w(8'h0B, 8'h00);
      ex_r(8'h0D, word[7:0]); ex_r(8'h0E, word[15:8]);
    end else begin
      tag = "R7"; nwait = PWW;
      ex_w(8'h0C, 8'h40 + {2'b0, ofs}); ex_w(8'h0D, wd[7:0]); ex_w(8'h0E, wd[15:8]);
      ex_w(8'h0B, 8'h0A); ex_w(8'h0B, 8'h00);
    end
  endtask

  logic [15:0] last_rd = 16'h0000;

  task automatic run_cmd(input logic t, input logic [1:0] op, input logic [5:0] ofs,
                         input logic [15:0] wd, input int b, input logic [15:0] word,
                         input bit jam);
    int nwait, n;
    string tag;
    bit seq_ok, pair_ok, jam_ok;
    build_exp(t, op, ofs, wd, b, word, nwait, tag);
    busy_n = b;
    @(negedge clk);
    log_n = 0;
    cmd_valid = 1; cmd_target = t; cmd_op = op; cmd_offset = ofs; cmd_wdata = wd;
    @(negedge clk);
    n = 1;
    jam_ok = 1;
    if (jam) begin
      cmd_target = ~t; cmd_op = 2'd1; cmd_offset = 6'd9; cmd_wdata = 16'hDEAD;
    end else cmd_valid = 0;
    while (!done && n < 2000) begin
      if (jam && ready) jam_ok = 0;
      @(negedge clk);
      n = n + 1;
      if (n > 6) cmd_valid = 0;
    end
    cmd_valid = 0;
    // R9: latency = accesses*2 + wait + 2
    chk(n == exp_n + nwait + 2, {"R9 latency ", tag}, n, exp_n + nwait + 2);
    seq_ok = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < 64; i++)
      if (log_ty[i] != exp_ty[i] || log_v[i] != exp_v[i]) seq_ok = 0;
    chk(seq_ok, {tag, " access trace"}, log_n, exp_n);
    if (b > 0) chk(seq_ok, "R8 busy poll repeat", log_n, exp_n);
    pair_ok = 1;
    for (int i = 0; i < log_n && i < 64; i++)
      if (log_ty[i] != 0 && (i == 0 || log_ty[i-1] != 0)) pair_ok = 0;
    chk(pair_ok, "R2 index before data", log_n, exp_n);
    if (jam) chk(jam_ok, "R11 busy ignores command", 0, 1);
    if (op == 2'd0) last_rd = word;
    if (op == 2'd0) chk(rdata == word, {tag, " rdata"}, rdata, word);
    else chk(rdata == last_rd, "R10 rdata held", rdata, last_rd);
    @(negedge clk);
    chk(!done && ready, "R10 done single pulse then ready", {done, ready}, 2'b01);
  endtask

  typedef struct packed {
    logic        t;
    logic [1:0]  op;
    logic [5:0]  ofs;
    logic [15:0] wd;
    logic [3:0]  b;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VT [0:7] = '{
    '{1'b0, 2'd1, 6'd5,  16'hA5C3, 4'd2, 16'h0000},
    '{1'b0, 2'd0, 6'd5,  16'h0000, 4'd0, 16'hA5C3},
    '{1'b1, 2'd1, 6'd4,  16'h01E1, 4'd0, 16'h0000},
    '{1'b1, 2'd0, 6'd4,  16'h0000, 4'd0, 16'h01E1},
    '{1'b0, 2'd2, 6'd0,  16'h0000, 4'd3, 16'h0000},
    '{1'b0, 2'd0, 6'd63, 16'h0000, 4'd1, 16'h1234},
    '{1'b1, 2'd0, 6'd31, 16'h0000, 4'd0, 16'hBEEF},
    '{1'b1, 2'd3, 6'd7,  16'h0000, 4'd0, 16'h0000}
  };

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'h00;
    for (int i = 0; i < 64; i++) begin
      eep_mem[i] = 16'(i * 3);
      phy_mem[i] = 16'(i * 5);
    end
    eep_mem[63] = 16'h1234;
    phy_mem[31] = 16'hBEEF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready && !done && !bus_wr && !bus_rd && rdata == 16'h0,
        "R1 reset state", {ready, done, bus_wr, bus_rd}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(ready && !done && !bus_wr && !bus_rd, "R1 after release",
        {ready, done, bus_wr, bus_rd}, 4'b1000);

    for (int k = 0; k < 8; k++)
      run_cmd(VT[k].t, VT[k].op, VT[k].ofs, VT[k].wd, int'(VT[k].b), VT[k].word, 0);

    // R11: competing command held high while busy
    run_cmd(1'b0, 2'd0, 6'd5, 16'h0, 2, 16'hA5C3, 1);
    chk(phy_mem[9] == 16'(9 * 5), "R11 no foreign write", phy_mem[9], 16'(9 * 5));

    // R1: reset in the middle of a poll
    busy_n = 6;
    @(negedge clk);
    cmd_valid = 1; cmd_target = 0; cmd_op = 2'd2; cmd_offset = 0;
    @(negedge clk);
    cmd_valid = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(ready && !done && !bus_wr && !bus_rd, "R1 mid-command reset",
        {ready, done, bus_wr, bus_rd}, 4'b1000);
    busy_cnt = 0; pend_dec = 0;
    rst_n = 1;
    last_rd = 16'h0000;
    run_cmd(1'b1, 2'd0, 6'd4, 16'h0, 0, 16'h01E1, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule